// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel keeps its count in two byte registers, a low byte and a high byte. A shared mode byte picks each channel's count layout, its source and its gating. A shared control byte holds the run enables and the sticky overflow flags. A channel counts in one of two ways:

- It advances once per machine cycle, which is a fixed group of 12 clocks.
- It counts falling edges on an external pin. The pin passes through a synchroniser and is sampled once per machine cycle.

Software reaches all six registers through a plain single-cycle register port. Writes happen on the clock edge and reads are combinational. The two overflow flags are also driven onto pins. All pins are plain control and status signals with no handshake, and every write is accepted in the cycle it is presented.

There are four count layouts:

- a 13-bit count built from five low bits and the whole high byte;
- a full 16-bit count;
- an 8-bit count that reloads itself;
- a split layout in which channel 0 works as two independent byte counters, while channel 1 halts if it is given that layout.

Top module: `tmr_dual`

## Requirements
- R1: After reset every register reads zero and both `ovf_flag` pins are low.
- R2: The machine-cycle strobe repeats every 12 clocks, with the first one on the 12th rising edge after reset is released. In timer source a running channel advances by exactly one on each strobe.
- R3: With layout code 01 the channel counts as a 16-bit value, high byte over low byte. Stepping past 16'hFFFF gives zero and sets the channel's flag.
- R4: With layout code 00 the channel counts 13 bits: low bits 4:0 carry into the high byte. Low bits 7:5 stay zero, and a write to the low byte stores only its bits 4:0. The flag sets when the count steps from high byte FF with low bits 11111.
- R5: With layout code 10 the low byte counts alone. Stepping it from FF loads the high byte's value into it and sets the flag. The high byte is not changed.
- R6: Channel 1 with layout code 11 holds both of its count bytes unchanged.
- R7: Channel 0 with layout code 11 splits into two byte counters:
  - The low byte counts per channel 0's run bit, gate and source, and on its wrap it sets flag 0.
  - The high byte counts machine cycles whenever run bit 1 is set, and on its wrap it sets flag 1.
  - While the split is in effect, a wrap of channel 1 does not set flag 1.
- R8: Control bit 6 is run bit 1 and control bit 4 is run bit 0. A channel whose run bit is clear keeps its count.
- R9: Mode bit 7 (channel 1) and mode bit 3 (channel 0) are the gate enables. When a gate enable is set, the channel counts only while its `gate_in` pin, after synchronisation, is high.
- R10: Mode bit 6 (channel 1) and mode bit 2 (channel 0) select the source, where 1 means pin edges and 0 means machine cycles.
  - In edge source the channel advances once for each 1-to-0 change of its `cnt_in` pin, seen at consecutive strobes.
  - Every falling edge is counted when the pin holds each level for at least 12 clocks.
  - A pin that holds its level does not advance the count.
- R11: Control bit 7 is flag 1 and control bit 5 is flag 0; `ovf_flag[1]` and `ovf_flag[0]` mirror them.
  - A flag stays set until software writes a 0 to it.
  - If a control write that clears a flag lands on the same edge as an overflow, the flag ends up set.
- R12: The register addresses are:
  - 0: mode byte, with channel 1 in bits 7:4 and channel 0 in bits 3:0, and the layout code in bits 5:4 and 1:0;
  - 1: control byte, with bits 3:0 reading zero;
  - 2 and 3: channel 0 low and high bytes;
  - 4 and 5: channel 1 low and high bytes;
  - 6 and 7: read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; writes `wr_data` to the register at `addr` on the rising edge |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| cnt_in | input | 2 | External count pins, bit c for channel c |
| gate_in | input | 2 | External gate pins, bit c for channel c |
| ovf_flag | output | 2 | Overflow flags, bit c for flag c |

## Verification
The checker watches these behaviours on every cycle:

- the 12-clock spacing of the machine-cycle strobe;
- that a halted channel 1 and a stopped channel 0 keep their counts;
- that the three high bits of the low byte stay clear in the 13-bit layout;
- the reload value on a low-byte wrap;
- that a set flag stays set when no control write occurs.

Exact counts after a known number of machine cycles, carries and wraps in every layout, the split-mode flag routing, and gating need the bench's scenarios. The same is true of edge counting at the highest input rate and of the overflow winning over a control write on the same edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_13     = 2'b00,
    MD_16     = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } tmr_mode_e;

  // per-channel nibble of the mode byte
  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_pins.sv
`timescale 1ns/1ps
module tmr_pins #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cnt_raw,
  input  logic gate_raw,
  output logic fall,
  output logic gate_lvl
);
  logic [STAGES-1:0] cnt_sh, gate_sh;
  logic              smp_q;
  logic              cnt_s;

  assign cnt_s    = cnt_sh[STAGES-1];
  assign gate_lvl = gate_sh[STAGES-1];
  assign fall     = tick & smp_q & ~cnt_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_sh  <= '0;
      gate_sh <= '0;
      smp_q   <= 1'b0;
    end else begin
      cnt_sh  <= {cnt_sh[STAGES-2:0], cnt_raw};
      gate_sh <= {gate_sh[STAGES-2:0], gate_raw};
      if (tick) smp_q <= cnt_s;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int LOW13 = 5,
  parameter bit SPLIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         step,
  input  logic         step_hi,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         wrap,
  output logic         wrap_hi
);
  logic [W-1:0] lo_n, hi_n;

  always_comb begin
    lo_n    = lo;
    hi_n    = hi;
    wrap    = 1'b0;
    wrap_hi = 1'b0;
    if (step) begin
      unique case (mode)
        MD_13: begin
          if (&lo[LOW13-1:0]) begin
            lo_n = '0;
            hi_n = hi + 1'b1;
            wrap = &hi;
          end else begin
            lo_n = W'(lo[LOW13-1:0]) + 1'b1;
          end
        end
        MD_16: begin
          {hi_n, lo_n} = {hi, lo} + 1'b1;
          wrap         = &{hi, lo};
        end
        MD_RELOAD: begin
          if (&lo) begin
            lo_n = hi;
            wrap = 1'b1;
          end else begin
            lo_n = lo + 1'b1;
          end
        end
        MD_SPLIT: begin
          if (SPLIT) begin
            lo_n = lo + 1'b1;
            wrap = &lo;
          end
        end
        default: ;
      endcase
    end
    if (SPLIT && mode == MD_SPLIT && step_hi) begin
      hi_n    = hi + 1'b1;
      wrap_hi = &hi;
    end
    // a software write owns the register on its edge
    if (wr_lo) lo_n = (mode == MD_13) ? W'(wr_data[LOW13-1:0]) : wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_dual.sv
`timescale 1ns/1ps
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int AW    = 3,
  parameter int DIV   = 12,
  parameter int SYNC  = 2,
  parameter int LOW13 = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  input  logic [1:0]    cnt_in,
  input  logic [1:0]    gate_in,
  output logic [1:0]    ovf_flag
);
  localparam int NCH = 2;
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_LO0  = AW'(2);

  logic [W-1:0]   mode_q;
  logic [NCH-1:0] run_q, flag_q;
  logic           tick;
  logic [NCH-1:0] fall, gate_lvl, step, wrap, wrap_hi, set_flag;
  logic [W-1:0]   cnt_lo [NCH];
  logic [W-1:0]   cnt_hi [NCH];
  chan_cfg_t      cfg    [NCH];
  logic           wr_ctrl, split0;

  tmr_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign split0  = (cfg[0].mode == MD_SPLIT);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cfg[c] = chan_cfg_t'(mode_q[4*c +: 4]);

    tmr_pins #(.STAGES(SYNC)) u_pins (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cnt_raw(cnt_in[c]), .gate_raw(gate_in[c]),
      .fall(fall[c]), .gate_lvl(gate_lvl[c])
    );

    assign step[c] = run_q[c] && (!cfg[c].gate || gate_lvl[c])
                     && (cfg[c].ext ? fall[c] : tick);

    tmr_chan #(.W(W), .LOW13(LOW13), .SPLIT(c == 0)) u_chan (
      .clk(clk), .rst_n(rst_n), .mode(cfg[c].mode), .step(step[c]),
      .step_hi((c == 0) ? (run_q[1] && tick) : 1'b0),
      .wr_lo(wr_en && addr == A_LO0 + AW'(2*c)),
      .wr_hi(wr_en && addr == A_LO0 + AW'(2*c + 1)),
      .wr_data(wr_data), .lo(cnt_lo[c]), .hi(cnt_hi[c]),
      .wrap(wrap[c]), .wrap_hi(wrap_hi[c])
    );
  end

  // flag 1 belongs to channel 0's upper half while channel 0 is split
  assign set_flag[0] = wrap[0];
  assign set_flag[1] = split0 ? wrap_hi[0] : (wrap[1] | wrap_hi[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && addr == A_MODE) mode_q <= wr_data;
      for (int c = 0; c < NCH; c++) begin
        if (wr_ctrl) run_q[c] <= wr_data[4 + 2*c];
        flag_q[c] <= (wr_ctrl ? wr_data[5 + 2*c] : flag_q[c]) | set_flag[c];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      AW'(0): rd_data = mode_q;
      AW'(1): rd_data = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
      AW'(2): rd_data = cnt_lo[0];
      AW'(3): rd_data = cnt_hi[0];
      AW'(4): rd_data = cnt_lo[1];
      AW'(5): rd_data = cnt_hi[1];
      default: rd_data = '0;
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_dual_chk.sv
`timescale 1ns/1ps
module tmr_dual_chk #(
  parameter int DIV = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] mode_q,
  input logic [1:0] run_q,
  input logic [1:0] flag_q,
  input logic       step0,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  logic [7:0] gap;
  logic       wr_ctrl, wr_c0, wr_c1;

  assign wr_ctrl = wr_en && addr == 3'd1;
  assign wr_c0   = wr_en && (addr == 3'd2 || addr == 3'd3);
  assign wr_c1   = wr_en && (addr == 3'd4 || addr == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n)    gap <= '0;
    else if (tick) gap <= '0;
    else           gap <= gap + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap == 8'(DIV - 1)); // R2

  AST_LOW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00 && lo0[7:5] == 3'b000) |=> lo0[7:5] == 3'b000); // R4

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b10 && step0 && lo0 == 8'hFF && !wr_c0)
    |=> lo0 == $past(hi0)); // R5

  AST_CH1_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !wr_c1) |=> ($stable(lo1) && $stable(hi1))); // R6

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && mode_q[1:0] != 2'b11 && !wr_c0)
    |=> ($stable(lo0) && $stable(hi0))); // R8

  AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !wr_ctrl) |=> flag_q[0]); // R11

  AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !wr_ctrl) |=> flag_q[1]); // R11
endmodule

bind tmr_dual tmr_dual_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .mode_q(mode_q), .run_q(run_q), .flag_q(flag_q), .step0(step[0]),
  .lo0(cnt_lo[0]), .hi0(cnt_hi[0]), .lo1(cnt_lo[1]), .hi1(cnt_hi[1])
);

// File: tb/sim_tmr_dual.sv
`timescale 1ns/1ps
module sim_tmr_dual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_in = 2'b11;
  logic [1:0] gate_in = 2'b00;
  logic [1:0] ovf_flag;
  int checks = 0, fails = 0, ecount = 0;
  bit done = 1'b0;

  tmr_dual u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
               .wr_data(wr_data), .rd_data(rd_data), .cnt_in(cnt_in),
               .gate_in(gate_in), .ovf_flag(ovf_flag));

  always #4 clk = ~clk;
  always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;

  // {ch, mode, ctrl, lo, hi, strobes, gate, exp_lo, exp_hi, exp_ctrl}
  localparam int NV = 15;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h10, 8'hFE, 8'h12, 8'd3, 2'b00, 8'h01, 8'h13, 8'h10},
    {1'b0, 8'h01, 8'h10, 8'hFF, 8'hFF, 8'd2, 2'b00, 8'h01, 8'h00, 8'h30},
    {1'b0, 8'h00, 8'h10, 8'h1E, 8'h05, 8'd3, 2'b00, 8'h01, 8'h06, 8'h10},
    {1'b0, 8'h00, 8'h10, 8'h1F, 8'hFF, 8'd1, 2'b00, 8'h00, 8'h00, 8'h30},
    {1'b0, 8'h02, 8'h10, 8'hFE, 8'h80, 8'd3, 2'b00, 8'h81, 8'h80, 8'h30},
    {1'b1, 8'h10, 8'h40, 8'hFE, 8'hFF, 8'd3, 2'b00, 8'h01, 8'h00, 8'hC0},
    {1'b1, 8'h20, 8'h40, 8'hFD, 8'hF0, 8'd4, 2'b00, 8'hF1, 8'hF0, 8'hC0},
    {1'b1, 8'h30, 8'h40, 8'h10, 8'h20, 8'd5, 2'b00, 8'h10, 8'h20, 8'h40},
    {1'b0, 8'h03, 8'h50, 8'hFE, 8'hFF, 8'd2, 2'b00, 8'h00, 8'h01, 8'hF0},
    {1'b0, 8'h09, 8'h10, 8'h40, 8'h00, 8'd4, 2'b00, 8'h40, 8'h00, 8'h10},
    {1'b0, 8'h09, 8'h10, 8'h40, 8'h00, 8'd4, 2'b01, 8'h44, 8'h00, 8'h10},
    {1'b1, 8'h90, 8'h40, 8'h00, 8'h00, 8'd2, 2'b10, 8'h02, 8'h00, 8'h40},
    {1'b0, 8'h00, 8'h00, 8'h33, 8'h44, 8'd3, 2'b00, 8'h13, 8'h44, 8'h00},
    {1'b0, 8'h00, 8'h10, 8'hE5, 8'h00, 8'd1, 2'b00, 8'h06, 8'h00, 8'h10},
    {1'b0, 8'h03, 8'h40, 8'h10, 8'hFE, 8'd3, 2'b00, 8'h10, 8'h01, 8'hC0}
  };
  localparam string TAG [NV] = '{"R2/R3", "R3", "R4", "R4", "R5", "R3", "R5",
    "R6", "R7", "R9", "R9", "R9", "R8", "R4", "R7"};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #0.5 v = rd_data;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 8'h00);
    end
    chk("R1 pins", {6'b0, ovf_flag}, 8'h00);
    rd(3'd6, v); chk("R12 unused addr", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [66:0] e;
      logic [2:0]  la;
      e  = VEC[i];
      la = e[66] ? 3'd4 : 3'd2;
      gate_in = e[25:24];
      wr(3'd1, 8'h00);
      wr(3'd0, e[65:58]);
      wr(la, e[49:42]);
      wr(la + 3'd1, e[41:34]);
      wr(3'd1, e[57:50]);
      repeat (12 * int'(e[33:26])) @(posedge clk);
      @(negedge clk);
      rd(la, v);         chk({TAG[i], " low"}, v, e[23:16]);
      rd(la + 3'd1, v);  chk({TAG[i], " high"}, v, e[15:8]);
      rd(3'd1, v);       chk({TAG[i], " ctrl"}, v, e[7:0]);
      chk({TAG[i], " R11 pins"}, {6'b0, ovf_flag}, {6'b0, e[7], e[5]});
    end
    gate_in = 2'b00;

    // R10: edge source, each level held 12 clocks, 5 falling edges
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    cnt_in[0] = 1'b1;
    repeat (30) @(negedge clk);
    wr(3'd1, 8'h10);
    for (int p = 0; p < 5; p++) begin
      repeat (12) @(negedge clk); cnt_in[0] = 1'b0;
      repeat (12) @(negedge clk); cnt_in[0] = 1'b1;
    end
    repeat (48) @(negedge clk);
    rd(3'd2, v); chk("R10 edge count", v, 8'h05);
    repeat (60) @(negedge clk);
    rd(3'd2, v); chk("R10 steady pin", v, 8'h05);

    // R11: control write clearing flag 0 on the overflow edge
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h10);
    do begin @(posedge clk); #1; end while (ecount % 12 != 0);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    repeat (9) @(posedge clk);
    wr(3'd1, 8'h10);
    @(negedge clk);
    rd(3'd1, v); chk("R11 overflow wins", v, 8'h30);
    rd(3'd2, v); chk("R2 R3 wrap low", v, 8'h00);
    chk("R11 pin", {6'b0, ovf_flag}, 8'h01);
    wr(3'd1, 8'h10);
    @(negedge clk);
    rd(3'd1, v); chk("R11 software clear", v, 8'h10);
    rd(3'd0, v); chk("R12 mode readback", v, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule